// File: doc/BRIEF.md
# UART Register Model with Receive Queue

This block is the register side of a serial port as software sees it. It sits on a single-cycle 32-bit slave port addressed by byte offset, and it decodes word slots (byte offset divided by four). A host-side agent hands received bytes in through a one-byte push strobe, and they wait in a 16-entry receive queue. Each write to the data slot sends a byte out on a transmit strobe. The block does no serial bit timing and no line coding, and it has no modem pins or DMA engine.

The block keeps status flags, raw, masked and clear interrupt registers, baud divisor and control storage, and a read-only identification window. It drives a registered level interrupt that is high when any raw interrupt bit is enabled in the mask. Read data is registered and appears in the cycle after the access. Side effects of an access, such as the pop on a data read, take effect on that same clock edge.

Top module: `uart_reg_model`

## Requirements
- R1: After reset, the flags slot (6) reads 0x90, the control slot (12) reads 0x300, the FIFO level slot (13) reads 0x12, and every other storage slot reads 0. The interrupt output is low.
- R2: The word slot is the byte offset shifted right by two. The following slots store the full written word and read it back: 8 (low-power divisor), 9 (integer divisor), 10 (fractional divisor), 11 (line control), 12 (control), 13 (FIFO level), 14 (interrupt mask) and 18 (DMA control).
- R3: A write to slot 0 raises txValid for exactly the following cycle, with txData equal to bits [7:0] of the written word. It also sets raw interrupt bit 5 (transmit).
- R4: A push stores the byte at the back of the queue, clears the empty flag (flags bit 4) and sets raw interrupt bit 4 (receive), because the trigger level is one.
- R5: The full flag (flags bit 6) is set on every push while line control bit 4 (FIFO enable) is 0. When FIFO enable is 1, it is set only when a push brings the count to 16. A data read clears it. Flags bit 7 is always 1.
- R6: A read of slot 0 returns the oldest byte, zero-extended, and removes it. When the queue is empty it returns 0. When the count reaches 0, the empty flag sets and raw bit 4 clears.
- R7: A push into a queue that holds 16 entries is dropped and sets the sticky raw interrupt bit 10 (overflow). The stored bytes are not changed.
- R8: A line control write that changes bit 4 discards the queued bytes. It sets the empty flag and clears the full flag and raw bit 4. A write that leaves bit 4 the same keeps the queue.
- R9: Writes to the flags slot have no effect on it.
- R10: Slot 16 reads raw status (slot 15) AND mask. The irq output equals the OR of (raw AND mask), registered one cycle after raw and mask.
- R11: A write to slot 17 clears every raw status bit that is 1 in the written word.
- R12: Word slots 0x3F8 to 0x3FF return the identification bytes 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in that order.
- R13: When a write to slot 18 has bit 0 or bit 1 set, dmaErr pulses high for one cycle. Otherwise dmaErr stays low.
- R14: Slot 1 (error status) reads 0 after a data read and after any write to it. Slots that are not decoded read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access request this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid the cycle after a read |
| rxPush | input | 1 | Push one received byte |
| rxPushData | input | 8 | Received byte |
| txValid | output | 1 | Transmit byte strobe |
| txData | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt |
| dmaErr | output | 1 | Pulse when an unsupported DMA request is written |

## Verification
Every one of the 1024 word slots is read straight after reset. This shows decoded slots against undecoded ones, and the identification window against its neighbours. Each storage slot is then written and read back with walking-one and alternating patterns, which catches stuck or swapped bits. All 256 byte values go through the transmit path. The receive queue is filled with a sequence whose values are computed, from empty up to overflow, and then drained. This shows whether ordering is kept, where the full flag switches as the count changes, and whether the receive interrupt clears at exactly zero. The same pushes are repeated with the FIFO disabled, and with line control writes that keep or toggle the enable bit, so the two full-flag rules and the discard rule can each be told apart.

// File: rtl/uart_rm_pkg.sv
package uart_rm_pkg;

  localparam int IDX_DATA   = 0;
  localparam int IDX_ERR    = 1;
  localparam int IDX_FLAG   = 6;
  localparam int IDX_ILP    = 8;
  localparam int IDX_IBRD   = 9;
  localparam int IDX_FBRD   = 10;
  localparam int IDX_LINE   = 11;
  localparam int IDX_CTRL   = 12;
  localparam int IDX_LVL    = 13;
  localparam int IDX_MASK   = 14;
  localparam int IDX_RAW    = 15;
  localparam int IDX_MIS    = 16;
  localparam int IDX_CLR    = 17;
  localparam int IDX_DMA    = 18;
  localparam int ID_FIRST   = 'h3F8;
  localparam int ID_LAST    = 'h3FF;

  localparam int RAW_RX_BIT      = 4;
  localparam int RAW_TX_BIT      = 5;
  localparam int RAW_OVF_BIT     = 10;
  localparam int FLAG_EMPTY_BIT  = 4;
  localparam int FLAG_FULL_BIT   = 6;
  localparam int LINE_FIFO_BIT   = 4;
  localparam int RX_TRIG         = 1;

  localparam logic [31:0] FLAG_RESET = 32'h90;
  localparam logic [31:0] CTRL_RESET = 32'h300;
  localparam logic [31:0] LVL_RESET  = 32'h12;

  typedef enum logic [3:0] {
    RD_NONE, RD_DATA, RD_ERR, RD_FLAG, RD_ILP, RD_IBRD, RD_FBRD, RD_LINE,
    RD_CTRL, RD_LVL, RD_MASK, RD_RAW, RD_MIS, RD_DMA, RD_ID
  } rdSel_e;

  typedef struct packed {
    logic   wrData;
    logic   wrErrClr;
    logic   wrIlp;
    logic   wrIbrd;
    logic   wrFbrd;
    logic   wrLine;
    logic   wrCtrl;
    logic   wrLvl;
    logic   wrMask;
    logic   wrClr;
    logic   wrDma;
    logic   rdAccess;
    rdSel_e rdSel;
    logic [2:0] idIdx;
  } regStrobe_t;

  function automatic logic [7:0] idByte(input logic [2:0] k);
    case (k)
      3'd0: idByte = 8'h11;
      3'd1: idByte = 8'h10;
      3'd2: idByte = 8'h14;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/uart_rm_ctrl.sv
module uart_rm_ctrl
  import uart_rm_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             busSel,
  input  logic             busWr,
  input  logic [IDX_W-1:0] wordIdx,
  output regStrobe_t       strobe
);

  logic wrEn;
  logic rdEn;
  logic inIdWin;

  assign wrEn    = busSel && busWr;
  assign rdEn    = busSel && !busWr;
  assign inIdWin = (wordIdx >= IDX_W'(ID_FIRST)) && (wordIdx <= IDX_W'(ID_LAST));

  always_comb begin
    strobe = '0;
    strobe.rdSel    = RD_NONE;
    strobe.rdAccess = rdEn;
    strobe.idIdx    = wordIdx[2:0];
    if (wrEn) begin
      case (wordIdx)
        IDX_W'(IDX_DATA): strobe.wrData   = 1'b1;
        IDX_W'(IDX_ERR):  strobe.wrErrClr = 1'b1;
        IDX_W'(IDX_ILP):  strobe.wrIlp    = 1'b1;
        IDX_W'(IDX_IBRD): strobe.wrIbrd   = 1'b1;
        IDX_W'(IDX_FBRD): strobe.wrFbrd   = 1'b1;
        IDX_W'(IDX_LINE): strobe.wrLine   = 1'b1;
        IDX_W'(IDX_CTRL): strobe.wrCtrl   = 1'b1;
        IDX_W'(IDX_LVL):  strobe.wrLvl    = 1'b1;
        IDX_W'(IDX_MASK): strobe.wrMask   = 1'b1;
        IDX_W'(IDX_CLR):  strobe.wrClr    = 1'b1;
        IDX_W'(IDX_DMA):  strobe.wrDma    = 1'b1;
        default: ;
      endcase
    end
    if (inIdWin) begin
      strobe.rdSel = RD_ID;
    end else begin
      case (wordIdx)
        IDX_W'(IDX_DATA): strobe.rdSel = RD_DATA;
        IDX_W'(IDX_ERR):  strobe.rdSel = RD_ERR;
        IDX_W'(IDX_FLAG): strobe.rdSel = RD_FLAG;
        IDX_W'(IDX_ILP):  strobe.rdSel = RD_ILP;
        IDX_W'(IDX_IBRD): strobe.rdSel = RD_IBRD;
        IDX_W'(IDX_FBRD): strobe.rdSel = RD_FBRD;
        IDX_W'(IDX_LINE): strobe.rdSel = RD_LINE;
        IDX_W'(IDX_CTRL): strobe.rdSel = RD_CTRL;
        IDX_W'(IDX_LVL):  strobe.rdSel = RD_LVL;
        IDX_W'(IDX_MASK): strobe.rdSel = RD_MASK;
        IDX_W'(IDX_RAW):  strobe.rdSel = RD_RAW;
        IDX_W'(IDX_MIS):  strobe.rdSel = RD_MIS;
        IDX_W'(IDX_DMA):  strobe.rdSel = RD_DMA;
        default:          strobe.rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/uart_rm_rxfifo.sv
module uart_rm_rxfifo #(
  parameter int ENTRY_W = 8,
  parameter int DEPTH   = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               push,
  input  logic [ENTRY_W-1:0] pushData,
  input  logic               pop,
  input  logic               flush,
  output logic [ENTRY_W-1:0] popData,
  output logic [CNT_W-1:0]   count,
  output logic [CNT_W-1:0]   cntAfterPop,
  output logic [CNT_W-1:0]   cntNext,
  output logic               pushDropped
);

  // DEPTH must be a power of two so that the pointers wrap naturally.
  logic [ENTRY_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]   wrPtr;
  logic [PTR_W-1:0]   rdPtr;
  logic               popOk;
  logic               pushOk;

  assign popOk       = pop && !flush && (count != '0);
  assign pushOk      = push && !flush && ((count != CNT_W'(DEPTH)) || popOk);
  assign pushDropped = push && !flush && !pushOk;
  assign cntAfterPop = count - CNT_W'(popOk);
  assign cntNext     = flush ? '0 : cntAfterPop + CNT_W'(pushOk);
  assign popData     = (count != '0) ? store[rdPtr] : '0;

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (pushOk && (wrPtr == PTR_W'(e))) begin
        store[e] <= pushData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      count <= cntNext;
      if (flush) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (pushOk) wrPtr <= wrPtr + 1'b1;
        if (popOk)  rdPtr <= rdPtr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_rm_dp.sv
module uart_rm_dp
  import uart_rm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              rxPush,
  input  logic [7:0]        rxPushData,
  output logic [DATA_W-1:0] busRdata,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              irq,
  output logic              dmaErr,
  output logic [DATA_W-1:0] rawStat,
  output logic [DATA_W-1:0] maskReg,
  output logic [DATA_W-1:0] flagReg,
  output logic [CNT_W-1:0]  rxCount
);

  logic [DATA_W-1:0] errStat, ilpReg, ibrdReg, fbrdReg, lineReg, ctrlReg, lvlReg, dmaReg;
  logic [DATA_W-1:0] rawNext, flagNext, rdMux;
  logic [7:0]        popData;
  logic [CNT_W-1:0]  cntAfterPop, cntNext;
  logic              popReq, flush, pushDropped, fifoEn;

  assign popReq = strobe.rdAccess && (strobe.rdSel == RD_DATA);
  assign fifoEn = lineReg[LINE_FIFO_BIT];
  assign flush  = strobe.wrLine && (busWdata[LINE_FIFO_BIT] != fifoEn);

  uart_rm_rxfifo #(.ENTRY_W(8), .DEPTH(DEPTH)) i_rxfifo (
    .clk        (clk),
    .rstN       (rstN),
    .push       (rxPush),
    .pushData   (rxPushData),
    .pop        (popReq),
    .flush      (flush),
    .popData    (popData),
    .count      (rxCount),
    .cntAfterPop(cntAfterPop),
    .cntNext    (cntNext),
    .pushDropped(pushDropped)
  );

  // Flag update: pop is applied before push within one cycle.
  always_comb begin
    flagNext = flagReg;
    if (flush) begin
      flagNext[FLAG_EMPTY_BIT] = 1'b1;
      flagNext[FLAG_FULL_BIT]  = 1'b0;
    end else begin
      if (popReq) begin
        flagNext[FLAG_FULL_BIT] = 1'b0;
        if (cntAfterPop == '0) flagNext[FLAG_EMPTY_BIT] = 1'b1;
      end
      if (rxPush) begin
        flagNext[FLAG_EMPTY_BIT] = 1'b0;
        if (!fifoEn || (cntNext == CNT_W'(DEPTH))) flagNext[FLAG_FULL_BIT] = 1'b1;
      end
    end
  end

  always_comb begin
    rawNext = rawStat;
    if (strobe.wrClr) rawNext = rawNext & ~busWdata;
    if (strobe.wrData) rawNext[RAW_TX_BIT] = 1'b1;
    if (flush) begin
      rawNext[RAW_RX_BIT] = 1'b0;
    end else begin
      if (popReq && (cntAfterPop == CNT_W'(RX_TRIG - 1))) rawNext[RAW_RX_BIT] = 1'b0;
      if (rxPush && (cntNext >= CNT_W'(RX_TRIG)))         rawNext[RAW_RX_BIT] = 1'b1;
      if (pushDropped)                                    rawNext[RAW_OVF_BIT] = 1'b1;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_DATA: rdMux = DATA_W'(popData);
      RD_ERR:  rdMux = errStat;
      RD_FLAG: rdMux = flagReg;
      RD_ILP:  rdMux = ilpReg;
      RD_IBRD: rdMux = ibrdReg;
      RD_FBRD: rdMux = fbrdReg;
      RD_LINE: rdMux = lineReg;
      RD_CTRL: rdMux = ctrlReg;
      RD_LVL:  rdMux = lvlReg;
      RD_MASK: rdMux = maskReg;
      RD_RAW:  rdMux = rawStat;
      RD_MIS:  rdMux = rawStat & maskReg;
      RD_DMA:  rdMux = dmaReg;
      RD_ID:   rdMux = DATA_W'(idByte(strobe.idIdx));
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errStat  <= '0;
      ilpReg   <= '0;
      ibrdReg  <= '0;
      fbrdReg  <= '0;
      lineReg  <= '0;
      ctrlReg  <= DATA_W'(CTRL_RESET);
      lvlReg   <= DATA_W'(LVL_RESET);
      maskReg  <= '0;
      dmaReg   <= '0;
      rawStat  <= '0;
      flagReg  <= DATA_W'(FLAG_RESET);
      busRdata <= '0;
      txValid  <= 1'b0;
      txData   <= '0;
      irq      <= 1'b0;
      dmaErr   <= 1'b0;
    end else begin
      rawStat <= rawNext;
      flagReg <= flagNext;
      irq     <= |(rawStat & maskReg);
      txValid <= strobe.wrData;
      dmaErr  <= strobe.wrDma && (|busWdata[1:0]);
      if (strobe.wrData)   txData  <= busWdata[7:0];
      if (strobe.wrErrClr) errStat <= '0;
      else if (popReq)     errStat <= DATA_W'(popData) >> 8;
      if (strobe.wrIlp)    ilpReg  <= busWdata;
      if (strobe.wrIbrd)   ibrdReg <= busWdata;
      if (strobe.wrFbrd)   fbrdReg <= busWdata;
      if (strobe.wrLine)   lineReg <= busWdata;
      if (strobe.wrCtrl)   ctrlReg <= busWdata;
      if (strobe.wrLvl)    lvlReg  <= busWdata;
      if (strobe.wrMask)   maskReg <= busWdata;
      if (strobe.wrDma)    dmaReg  <= busWdata;
      if (strobe.rdAccess) busRdata <= rdMux;
    end
  end

endmodule

// File: rtl/uart_reg_model.sv
module uart_reg_model
  import uart_rm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = ADDR_W - 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxPush,
  input  logic [7:0]        rxPushData,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              irq,
  output logic              dmaErr
);

  regStrobe_t        strobe;
  logic [DATA_W-1:0] rawStat, maskReg, flagReg;
  logic [CNT_W-1:0]  rxCount;
  logic              unusedLowAddr;

  assign unusedLowAddr = ^busAddr[1:0];

  uart_rm_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .wordIdx(busAddr[ADDR_W-1:2]),
    .strobe (strobe)
  );

  uart_rm_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWdata  (busWdata),
    .rxPush    (rxPush),
    .rxPushData(rxPushData),
    .busRdata  (busRdata),
    .txValid   (txValid),
    .txData    (txData),
    .irq       (irq),
    .dmaErr    (dmaErr),
    .rawStat   (rawStat),
    .maskReg   (maskReg),
    .flagReg   (flagReg),
    .rxCount   (rxCount)
  );

endmodule

// File: rtl/uart_reg_model_chk.sv
module uart_reg_model_chk
  import uart_rm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              txValid,
  input logic              irq,
  input logic              dmaErr,
  input logic [DATA_W-1:0] rawStat,
  input logic [DATA_W-1:0] maskReg,
  input logic [DATA_W-1:0] flagReg,
  input logic [CNT_W-1:0]  rxCount
);

  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R3
  tx_raw_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> rawStat[RAW_TX_BIT]);

  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (irq == |($past(rawStat) & $past(maskReg))));

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(DEPTH));

  // R4
  empty_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagReg[FLAG_EMPTY_BIT] == (rxCount == '0));

  // R6
  rx_raw_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == '0) |-> !rawStat[RAW_RX_BIT]);

  // R13
  dma_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && dmaErr) |->
      $past(busSel && busWr && (busAddr[ADDR_W-1:2] == (ADDR_W-2)'(IDX_DMA)) && (|busWdata[1:0])));

endmodule

bind uart_reg_model uart_reg_model_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWr   (busWr),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .txValid (txValid),
  .irq     (irq),
  .dmaErr  (dmaErr),
  .rawStat (rawStat),
  .maskReg (maskReg),
  .flagReg (flagReg),
  .rxCount (rxCount)
);

// File: tb/test_uart_reg_model.sv
module test_uart_reg_model;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rxPush = 1'b0;
  logic [7:0]  rxPushData = '0;
  logic        txValid, irq, dmaErr;
  logic [7:0]  txData;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_reg_model i_uart_reg_model (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rxPush(rxPush), .rxPushData(rxPushData),
    .txValid(txValid), .txData(txData), .irq(irq), .dmaErr(dmaErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input int idx, input logic [31:0] v);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = ADDR_W'(idx * 4); busWdata = v;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input int idx, output logic [31:0] r);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = ADDR_W'(idx * 4);
    @(negedge clk);
    busSel = 1'b0;
    r = busRdata;
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    rxPush = 1'b1; rxPushData = b;
    @(negedge clk);
    rxPush = 1'b0;
  endtask

  function automatic logic [31:0] expAfterReset(input int idx);
    case (idx)
      6:  return 32'h90;
      12: return 32'h300;
      13: return 32'h12;
      'h3F8: return 32'h11;
      'h3F9: return 32'h10;
      'h3FA: return 32'h14;
      'h3FB: return 32'h00;
      'h3FC: return 32'h0D;
      'h3FD: return 32'hF0;
      'h3FE: return 32'h05;
      'h3FF: return 32'hB1;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] seqByte(input int n);
    return 8'((n * 37 + 11) & 'hFF);
  endfunction

  function automatic logic [31:0] flagsExp(input logic full, input logic empty);
    return 32'h80 | (32'(full) << 6) | (32'(empty) << 4);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: irq low after reset
    chk("R1 irq", 32'(irq), 32'h0);
    // R1 R12 R14: sweep every word slot after reset
    for (int idx = 0; idx < 1024; idx++) begin
      busRead(idx, r);
      chk($sformatf("R1/R12/R14 slot %0h", idx), r, expAfterReset(idx));
    end

    // R2: storage readback with walking ones and alternating patterns
    begin
      int slots[7] = '{8, 9, 10, 12, 13, 14, 18};
      foreach (slots[s]) begin
        for (int b = 0; b < 34; b++) begin
          logic [31:0] pat;
          pat = (b < 32) ? (32'h1 << b) : ((b == 32) ? 32'hA5A5_5A5A : 32'h5A5A_A5A4);
          if (slots[s] == 18) pat = pat & 32'hFFFF_FFFC;
          busWrite(slots[s], pat);
          busRead(slots[s], r);
          chk($sformatf("R2 slot %0d", slots[s]), r, pat);
        end
        busWrite(slots[s], 32'h0);
      end
      busWrite(11, 32'hFFFF_FFEF);
      busRead(11, r);
      chk("R2 line", r, 32'hFFFF_FFEF);
      busWrite(11, 32'h0);
    end

    // R9: flag writes ignored
    busWrite(6, 32'hFFFF_FFFF);
    busRead(6, r);
    chk("R9 flags", r, 32'h90);

    // R3: every byte value on the transmit strobe
    for (int b = 0; b < 256; b++) begin
      busWrite(0, {24'hABCDEF, 8'(b)});
      chk("R3 txValid", 32'(txValid), 32'h1);
      chk("R3 txData", 32'(txData), 32'(b));
    end
    @(negedge clk);
    chk("R3 txValid single", 32'(txValid), 32'h0);
    busRead(15, r);
    chk("R3 raw tx", r, 32'h20);
    // R11
    busWrite(17, 32'h20);
    busRead(15, r);
    chk("R11 clear", r, 32'h0);

    // R10: masked status and irq
    busWrite(14, 32'h20);
    busWrite(0, 32'h41);
    @(negedge clk);
    chk("R10 irq set", 32'(irq), 32'h1);
    busRead(16, r);
    chk("R10 masked", r, 32'h20);
    busWrite(14, 32'h10);
    busRead(16, r);
    chk("R10 masked off", r, 32'h0);
    @(negedge clk);
    chk("R10 irq masked", 32'(irq), 32'h0);
    busWrite(17, 32'hFFFF_FFFF);

    // R4 R5 R7: FIFO enabled, fill to overflow
    busWrite(11, 32'h10);
    for (int n = 1; n <= 16; n++) begin
      pushByte(seqByte(n));
      busRead(6, r);
      chk($sformatf("R5 flags n=%0d", n), r, flagsExp(n == 16, 1'b0));
      busRead(15, r);
      chk("R4 raw rx", r, 32'h10);
    end
    @(negedge clk);
    chk("R10 irq rx", 32'(irq), 32'h1);
    pushByte(8'hEE);
    busRead(15, r);
    chk("R7 overflow", r, 32'h410);
    // R6: drain in order
    for (int n = 1; n <= 16; n++) begin
      busRead(0, r);
      chk($sformatf("R6 pop n=%0d", n), r, 32'(seqByte(n)));
      busRead(6, r);
      chk($sformatf("R6 flags n=%0d", n), r, flagsExp(1'b0, n == 16));
      busRead(15, r);
      chk("R6 raw rx", r, (n == 16) ? 32'h400 : 32'h410);
    end
    busRead(0, r);
    chk("R6 empty pop", r, 32'h0);
    // R14
    busRead(1, r);
    chk("R14 errstat", r, 32'h0);
    busWrite(1, 32'hFFFF_FFFF);
    busRead(1, r);
    chk("R14 errstat clr", r, 32'h0);
    busWrite(17, 32'h400);

    // R5: FIFO disabled, every push sets full
    busWrite(11, 32'h0);
    pushByte(8'h5C);
    busRead(6, r);
    chk("R5 full disabled", r, flagsExp(1'b1, 1'b0));
    busRead(0, r);
    chk("R6 pop disabled", r, 32'h5C);
    busRead(6, r);
    chk("R5 full cleared", r, flagsExp(1'b0, 1'b1));

    // R8: toggle discards, same value keeps
    busWrite(11, 32'h10);
    for (int n = 0; n < 3; n++) pushByte(seqByte(n + 40));
    busWrite(11, 32'h70);
    busRead(6, r);
    chk("R8 keep", r, flagsExp(1'b0, 1'b0));
    busWrite(11, 32'h60);
    busRead(6, r);
    chk("R8 flush flags", r, flagsExp(1'b0, 1'b1));
    busRead(15, r);
    chk("R8 flush raw", r, 32'h0);
    busRead(0, r);
    chk("R8 flush data", r, 32'h0);

    // R13: DMA request bits
    for (int v = 0; v < 8; v++) begin
      busWrite(18, 32'(v));
      chk($sformatf("R13 dmaErr v=%0d", v), 32'(dmaErr), 32'((v & 3) != 0));
      busRead(18, r);
      chk("R13 dma store", r, 32'(v));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule